// File: doc/BRIEF.md
# Framed Serial Transaction Handshake

This block sits between a byte-wide serial receiver/transmitter pair and the command logic of a device. It carries out the link-level handshake that wraps every host command. The host opens a transaction with an enquiry byte and then sends a start-of-text byte. The device answers with an acknowledge. The host then streams the payload and closes it with an end-of-transmission byte. The device finally answers with either an acknowledge or a negative acknowledge. Large transfers, such as an image upload, are sent as a series of chunks, and each chunk travels in its own transaction.

Payload bytes are stored in an internal buffer. When the closing byte arrives, the complete payload is offered to the command logic, which reads it through a random-access read port and later returns a done strobe with a pass/fail result. That result selects the final reply. The block never parses the payload.

When no transaction is open, a free-running monitor byte stream is passed straight to the transmitter. From the moment the opening byte is accepted until the final reply has been sent, that stream is held off, so that no stray text can be mixed into the framed exchange. A silence watchdog drops a stalled transaction, and a payload that exceeds the buffer always ends in a refusal.

Top module: `frame_link`

## Requirements
- R1: While idle, the monitor stream passes through combinationally: `tx_valid`=`mon_valid`, `tx_data`=`mon_data`, and `mon_ready`=`tx_ready`.
- R2: Control byte values are: enquiry 0x05, start 0x02, acknowledge 0x06, end 0x04, refusal 0x15. An enquiry received while idle, followed by a start byte, makes the block transmit exactly one 0x06, and the payload phase then begins.
- R3: A byte other than 0x05 received while idle is ignored. A byte other than 0x02 received in place of the start byte returns the block to idle without transmitting anything.
- R4: Every non-0x04 byte received in the payload phase is stored in arrival order at address 0, 1, 2, and so on. On 0x04, `pl_valid` rises, `pl_len` gives the byte count, and `rd_data` returns the byte stored at `rd_addr`. `pl_valid` stays high until `cmd_done`.
- R5: The final reply is sent only after `cmd_done` is seen while `pl_valid` is high. It is 0x06 when `cmd_ok`=1 and 0x15 otherwise. Exactly one reply byte is sent per transaction.
- R6: A payload of more than DEPTH bytes keeps only the first DEPTH bytes. The closing 0x04 then produces 0x15 directly, and `pl_valid` is never raised. A payload of exactly DEPTH bytes is handled normally.
- R7: If, while waiting for the start byte or for payload bytes, more than TIMEOUT_CYC clock cycles pass without a received byte, the block returns to idle without a reply. A gap shorter than that keeps the transaction alive.
- R8: From the accepted enquiry until the final reply has been sent, `mon_ready` is low and no monitor byte reaches `tx_data`.
- R9: A pending reply byte holds `tx_valid` high and `tx_data` stable while `tx_ready` is low.
- R10: After reset the block is idle: `pl_valid`=0, `pl_len`=0, and no reply is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| mon_valid | input | 1 | Monitor stream has a byte |
| mon_data | input | 8 | Monitor stream byte |
| mon_ready | output | 1 | Monitor byte taken this cycle |
| pl_valid | output | 1 | Complete payload waiting for the command logic |
| pl_len | output | $clog2(DEPTH+1) | Payload byte count |
| rd_addr | input | $clog2(DEPTH) | Payload read address |
| rd_data | output | 8 | Payload byte at `rd_addr` |
| cmd_done | input | 1 | Command logic finished with the payload |
| cmd_ok | input | 1 | Command result, sampled with `cmd_done` |

## Verification
The bench builds the block with DEPTH=8 and TIMEOUT_CYC=40. The small buffer lets a full payload and a payload one byte too long both be sent in a handful of cycles. The short window lets both sides of the silence limit be tested: a gap just under it keeps the transaction open, and a gap just over it drops the transaction. Together with a transmitter that is held busy and command logic that answers late, these settings cover every state of the handshake, including the refusal path.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;

  localparam logic [7:0] C_ENQ  = 8'h05;
  localparam logic [7:0] C_STX  = 8'h02;
  localparam logic [7:0] C_ACK  = 8'h06;
  localparam logic [7:0] C_EOT  = 8'h04;
  localparam logic [7:0] C_NACK = 8'h15;

  typedef enum logic [2:0] {
    ST_IDLE,   // no transaction, monitor stream owns the transmitter
    ST_WSTX,   // enquiry seen, waiting for the start byte
    ST_HSK,    // sending the opening acknowledge
    ST_BODY,   // collecting payload bytes
    ST_CMD,    // payload handed over, waiting for the command verdict
    ST_REPLY   // sending the final verdict byte
  } link_st_e;

  // Final verdict: refuse on buffer overflow or on a failed command.
  function automatic logic [7:0] verdict_code(input logic ovf, input logic ok);
    return (!ovf && ok) ? C_ACK : C_NACK;
  endfunction

  // True once the stored count has reached the buffer capacity.
  function automatic logic buf_full(input int unsigned cnt, input int unsigned cap);
    return cnt >= cap;
  endfunction

endpackage

// File: rtl/frame_link_timer.sv
module frame_link_timer #(
  parameter int TIMEOUT_CYC = 100000,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || kick)
      cnt_q <= '0;
    else if (cnt_q != CW'(TIMEOUT_CYC))
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && !kick && (cnt_q == CW'(TIMEOUT_CYC));

endmodule

// File: rtl/frame_link_buf.sv
module frame_link_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/frame_link.sv
module frame_link
  import frame_link_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int TIMEOUT_CYC = 100000,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          mon_valid,
  input  logic [7:0]    mon_data,
  output logic          mon_ready,
  output logic          pl_valid,
  output logic [LW-1:0] pl_len,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          cmd_done,
  input  logic          cmd_ok
);

  link_st_e      st_q, st_d;
  logic [LW-1:0] len_q;
  logic          err_q;
  logic [7:0]    reply_q;

  // Named internal events, also observed by the checker.
  logic idle_w, wait_w, reply_w, hsk_w;
  logic tmo_w, eot_w, data_w, store_w, ovf_evt_w, full_w;

  assign idle_w  = (st_q == ST_IDLE);
  assign wait_w  = (st_q == ST_CMD);
  assign reply_w = (st_q == ST_REPLY);
  assign hsk_w   = (st_q == ST_HSK);

  assign eot_w     = (st_q == ST_BODY) && rx_valid && (rx_data == C_EOT);
  assign data_w    = (st_q == ST_BODY) && rx_valid && (rx_data != C_EOT);
  assign full_w    = buf_full(int'(len_q), DEPTH);
  assign store_w   = data_w && !full_w;
  assign ovf_evt_w = data_w && full_w;

  frame_link_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     ((st_q == ST_WSTX) || (st_q == ST_BODY)),
    .kick    (rx_valid),
    .expired (tmo_w)
  );

  frame_link_buf #(.DEPTH(DEPTH)) buf_i (
    .clk     (clk),
    .wr_en   (store_w),
    .wr_addr (len_q[AW-1:0]),
    .wr_data (rx_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (rx_valid && rx_data == C_ENQ) st_d = ST_WSTX;
      ST_WSTX: begin
        if (tmo_w)         st_d = ST_IDLE;
        else if (rx_valid) st_d = (rx_data == C_STX) ? ST_HSK : ST_IDLE;
      end
      ST_HSK:   if (tx_ready) st_d = ST_BODY;
      ST_BODY: begin
        if (tmo_w)      st_d = ST_IDLE;
        else if (eot_w) st_d = (err_q || ovf_evt_w) ? ST_REPLY : ST_CMD;
      end
      ST_CMD:   if (cmd_done) st_d = ST_REPLY;
      ST_REPLY: if (tx_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      len_q   <= '0;
      err_q   <= 1'b0;
      reply_q <= C_NACK;
    end else begin
      st_q <= st_d;
      if (hsk_w) begin
        len_q <= '0;
        err_q <= 1'b0;
      end
      if (store_w)   len_q <= len_q + 1'b1;
      if (ovf_evt_w) err_q <= 1'b1;
      if (eot_w && err_q) reply_q <= verdict_code(1'b1, 1'b0);
      if (wait_w && cmd_done) reply_q <= verdict_code(err_q, cmd_ok);
    end
  end

  assign tx_valid  = idle_w ? mon_valid : (hsk_w || reply_w);
  assign tx_data   = idle_w ? mon_data : (hsk_w ? C_ACK : reply_q);
  assign mon_ready = idle_w && tx_ready;
  assign pl_valid  = wait_w;
  assign pl_len    = len_q;

endmodule

// File: rtl/frame_link_chk.sv
module frame_link_chk
  import frame_link_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_w,
  input logic          wait_w,
  input logic          reply_w,
  input logic          tmo_w,
  input logic          err_q,
  input logic [LW-1:0] len_q,
  input logic          mon_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          cmd_done
);

  assert_mon_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_w |-> !mon_ready);

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LW'(DEPTH));

  assert_ovf_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_w && err_q) |-> (tx_data == C_NACK));

  assert_verdict_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_w && $past(wait_w)) |-> $past(cmd_done));

  assert_reply_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_w && tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_w |=> idle_w);

endmodule

bind frame_link frame_link_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle_w    (idle_w),
  .wait_w    (wait_w),
  .reply_w   (reply_w),
  .tmo_w     (tmo_w),
  .err_q     (err_q),
  .len_q     (len_q),
  .mon_ready (mon_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .cmd_done  (cmd_done)
);

// File: tb/frame_link_tb_top.sv
module frame_link_tb_top;

  localparam int DEPTH = 8;
  localparam int TMO   = 40;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NV    = 8;

  // Each row: {first byte, second byte, payload length, cmd_ok, expected verdict (0 = no reply)}
  localparam logic [39:0] VEC [NV] = '{
    {8'h05, 8'h02, 8'd3, 8'd1, 8'h06},
    {8'h05, 8'h02, 8'd0, 8'd1, 8'h06},
    {8'h05, 8'h02, 8'd5, 8'd0, 8'h15},
    {8'h05, 8'h02, 8'd8, 8'd1, 8'h06},
    {8'h05, 8'h02, 8'd9, 8'd1, 8'h15},
    {8'h05, 8'h41, 8'd0, 8'd0, 8'h00},
    {8'h41, 8'h02, 8'd0, 8'd0, 8'h00},
    {8'h05, 8'h05, 8'd0, 8'd0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic mon_valid = 1'b0;
  logic [7:0] mon_data = 8'h00;
  logic mon_ready;
  logic pl_valid;
  logic [LW-1:0] pl_len;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic cmd_done = 1'b0;
  logic cmd_ok = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int log_n = 0;
  logic [7:0] log_b [8];

  always #10 clk = ~clk;

  frame_link #(.DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mon_valid(mon_valid), .mon_data(mon_data), .mon_ready(mon_ready),
    .pl_valid(pl_valid), .pl_len(pl_len), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_done(cmd_done), .cmd_ok(cmd_ok)
  );

  // Record every byte the transmitter accepts.
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (log_n < 8) log_b[log_n] = tx_data;
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int r, input int i);
    return 8'(8'h30 + r * 16 + i);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    check("R10 tx_valid", int'(tx_valid), 0);
    check("R10 pl_valid", int'(pl_valid), 0);
    check("R10 pl_len", int'(pl_len), 0);
    check("R10 mon_ready", int'(mon_ready), 1);

    // Table-driven transactions
    for (int r = 0; r < NV; r++) begin
      logic [7:0] b0, b1, ln, ok, ex;
      int bad;
      {b0, b1, ln, ok, ex} = VEC[r];
      log_n = 0;
      send(b0);
      send(b1);
      if (ex == 8'h00) begin
        idle(3);
        check("R3 no reply", log_n, 0);
        check("R3 back to idle", int'(mon_ready), 1);
        continue;
      end
      idle(2);
      check("R2 opening ack count", log_n, 1);
      check("R2 opening ack code", int'(log_b[0]), 8'h06);
      for (int i = 0; i < int'(ln); i++) send(pat(r, i));
      send(8'h04);
      idle(1);
      if (int'(ln) <= DEPTH) begin
        check("R4 pl_valid", int'(pl_valid), 1);
        check("R4 pl_len", int'(pl_len), int'(ln));
        bad = 0;
        for (int i = 0; i < int'(ln); i++) begin
          rd_addr = AW'(i);
          #1;
          if (rd_data != pat(r, i)) bad++;
        end
        check("R4 payload bytes", bad, 0);
        idle(2);
        check("R5 no verdict before done", log_n, 1);
        cmd_ok = ok[0];
        cmd_done = 1'b1;
        idle(1);
        cmd_done = 1'b0;
      end else begin
        check("R6 overflow no hand-off", int'(pl_valid), 0);
      end
      idle(3);
      check("R5 reply count", log_n, 2);
      check((int'(ln) > DEPTH) ? "R6 overflow verdict" : "R5 verdict", int'(log_b[1]), int'(ex));
      check("R5 idle after reply", int'(mon_ready), 1);
    end

    // R1 monitor passthrough while idle
    mon_data = 8'h5A;
    mon_valid = 1'b1;
    #1;
    check("R1 tx_valid", int'(tx_valid), 1);
    check("R1 tx_data", int'(tx_data), 8'h5A);
    check("R1 mon_ready", int'(mon_ready), 1);
    mon_valid = 1'b0;
    idle(2);

    // R8 monitor blocked during a transaction
    send(8'h05);
    mon_valid = 1'b1;
    #1;
    check("R8 mon_ready low", int'(mon_ready), 0);
    check("R8 tx_valid low", int'(tx_valid), 0);
    mon_valid = 1'b0;
    send(8'h33);
    idle(1);
    check("R3 bad start byte to idle", int'(mon_ready), 1);

    // R7 timeout while waiting for the start byte
    send(8'h05);
    idle(TMO + 4);
    check("R7 timeout to idle", int'(mon_ready), 1);
    log_n = 0;
    send(8'h02);
    idle(3);
    check("R7 late start ignored", log_n, 0);

    // R7 gap below limit keeps transaction; then timeout in payload phase
    send(8'h05);
    idle(TMO - 3);
    send(8'h02);
    idle(2);
    check("R7 short gap ack", log_n, 1);
    send(8'h61);
    idle(TMO + 4);
    check("R7 payload timeout idle", int'(mon_ready), 1);
    send(8'h04);
    idle(3);
    check("R7 stale end ignored", int'(pl_valid), 0);
    check("R7 no reply after abort", log_n, 1);

    // R9 reply held under back-pressure
    log_n = 0;
    tx_ready = 1'b0;
    send(8'h05);
    send(8'h02);
    idle(5);
    check("R9 ack held valid", int'(tx_valid), 1);
    check("R9 ack held code", int'(tx_data), 8'h06);
    tx_ready = 1'b1;
    idle(2);
    check("R9 ack delivered once", log_n, 1);
    send(8'h04);
    idle(5);
    check("R5 late command no reply", log_n, 1);
    tx_ready = 1'b0;
    cmd_ok = 1'b0;
    cmd_done = 1'b1;
    idle(1);
    cmd_done = 1'b0;
    idle(4);
    check("R9 verdict held code", int'(tx_data), 8'h15);
    check("R9 verdict held valid", int'(tx_valid), 1);
    tx_ready = 1'b1;
    idle(3);
    check("R5 refusal delivered", int'(log_b[1]), 8'h15);

    finish_run();
  end

endmodule